// File: doc/BRIEF.md
# Dual-Slot Warp Issue Scheduler

This block chooses which resident warps send their next instruction to the shared execution hardware in each cycle. Sixteen warps of 32 threads live in the pool. Two issue slots run side by side. Slot 0 owns the even warp IDs and slot 1 owns the odd ones. In every cycle each slot may launch one instruction to one of three execution groups: a 16-lane arithmetic group, a 16-lane load/store group, or a 4-lane group for transcendental functions such as sine, reciprocal and square root. Warps do not depend on one another, so the scheduler does no cross-warp hazard checking. A warp that is waiting on a load is passed over, and another warp of the same slot issues in its place, which hides memory latency.

A 32-thread warp needs several passes through a narrow group. An internal counter per group keeps that group marked occupied for WARP_SIZE/lanes cycles, counted from the issue cycle. The issue outputs are strobes and carry no ready. Back-pressure comes from the per-group `grp_hold` inputs: while a hold bit is high, nothing issues to that group, and no issue state changes on its behalf. Issue outputs are combinational from the inputs and registered state in the same cycle. All state advances on the rising clock edge.

Top module: `warp_issue_sched`

## Requirements
- R1: While `rst` is high, neither slot issues. After reset, every group is free, no warp is stalled, and each slot's search starts from its lowest warp ID.
- R2: Slot 0 issues only even warp IDs and slot 1 issues only odd warp IDs.
- R3: A warp can issue only when its `warp_valid` bit is high, it is not stalled, and its target group is free.
- R4: Each slot picks in round-robin order among its eligible warps. The search starts just after the warp that slot issued last and wraps around.
- R5: The two slots never issue to the same group in the same cycle. Slot 0 has priority. On a clash, slot 1 picks its next eligible warp that targets a different group, or it stays idle.
- R6: An issue to the arithmetic group or the load/store group blocks that group for the issue cycle and the next cycle (2 cycles). An issue to the special-function group blocks it for 8 cycles. The group can take a new issue in the cycle after that.
- R7: Issuing a load/store instruction stalls that warp from the next cycle on. A `done_valid` pulse that names the warp clears the stall from the following cycle. It does not free the warp within the cycle of the pulse.
- R8: While `grp_hold[g]` is high, no slot issues to group g. Issues to other groups continue.
- R9: Class codes per warp, in `warp_cls[2w+1:2w]`: 0 is arithmetic, 1 is load/store, 2 is special function, and 3 is "no instruction", which never issues.
- R10: The group field of an issue equals the class code of the issued warp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| warp_valid | input | NUM_WARPS | Warp holds a decoded instruction ready to go |
| warp_cls | input | 2*NUM_WARPS | Group class of each warp's next instruction, 2 bits per warp |
| grp_hold | input | 3 | Per-group back-pressure: bit 0 arithmetic, 1 load/store, 2 special |
| done_valid | input | 1 | Pulse: a long-latency load has completed |
| done_warp | input | log2(NUM_WARPS) | Warp whose load completed |
| iss0_valid | output | 1 | Slot 0 issues this cycle |
| iss0_warp | output | log2(NUM_WARPS) | Warp issued by slot 0 |
| iss0_grp | output | 2 | Target group of slot 0 |
| iss1_valid | output | 1 | Slot 1 issues this cycle |
| iss1_warp | output | log2(NUM_WARPS) | Warp issued by slot 1 |
| iss1_grp | output | 2 | Target group of slot 1 |

## Verification
A round-robin pointer left at the wrong value shows up at the next issue of that slot, as a warp out of its expected order. A busy counter that is loaded with the wrong value shows a group taking an issue too early or too late, within at most eight cycles. A stall flag that is never set lets a load warp issue again two cycles after its load. A stall flag that is never cleared leaves the warp silent forever after its completion pulse. The directed scenarios place each of these on a known cycle and check that cycle.

// File: rtl/wis_pkg.sv
package wis_pkg;
  typedef enum logic [1:0] {
    GRP_ALU  = 2'd0,
    GRP_LSU  = 2'd1,
    GRP_SFU  = 2'd2,
    GRP_NONE = 2'd3
  } grp_e;

  localparam int NUM_GRP = 3;
endpackage

// File: rtl/wis_rr_pick.sv
// Rotating first-set search: lowest request at or after 'start', with wrap.
module wis_rr_pick #(
  parameter int N = 8,
  parameter int W = $clog2(N)
) (
  input  logic [N-1:0] req,
  input  logic [W-1:0] start,
  output logic         found,
  output logic [W-1:0] idx
);
  int p;
  always_comb begin
    found = 1'b0;
    idx   = '0;
    p     = 0;
    for (int k = 0; k < N; k++) begin
      p = int'(start) + k;
      if (p >= N) p = p - N;
      if (!found && req[p]) begin
        found = 1'b1;
        idx   = W'(p);
      end
    end
  end
endmodule

// File: rtl/wis_grp_timer.sv
// Occupancy counter for one execution group: blocked for HOLD cycles from load.
module wis_grp_timer #(
  parameter int HOLD = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic busy
);
  localparam int CW = $clog2(HOLD + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= CW'(HOLD - 1);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
  import wis_pkg::*;
#(
  parameter int NUM_WARPS = 16,
  parameter int WARP_SIZE = 32,
  parameter int ALU_LANES = 16,
  parameter int LSU_LANES = 16,
  parameter int SFU_LANES = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_WARPS-1:0]         warp_valid,
  input  logic [2*NUM_WARPS-1:0]       warp_cls,
  input  logic [2:0]                   grp_hold,
  input  logic                         done_valid,
  input  logic [$clog2(NUM_WARPS)-1:0] done_warp,
  output logic                         iss0_valid,
  output logic [$clog2(NUM_WARPS)-1:0] iss0_warp,
  output logic [1:0]                   iss0_grp,
  output logic                         iss1_valid,
  output logic [$clog2(NUM_WARPS)-1:0] iss1_warp,
  output logic [1:0]                   iss1_grp
);
  localparam int WID      = $clog2(NUM_WARPS);
  localparam int PER_SLOT = NUM_WARPS / 2;
  localparam int PW       = $clog2(PER_SLOT);
  localparam int ALU_HOLD = WARP_SIZE / ALU_LANES;
  localparam int LSU_HOLD = WARP_SIZE / LSU_LANES;
  localparam int SFU_HOLD = WARP_SIZE / SFU_LANES;

  logic [1:0]           cls_arr [NUM_WARPS];
  logic [NUM_WARPS-1:0] elig;
  logic [NUM_WARPS-1:0] stall_q;
  logic [NUM_GRP-1:0]   grp_busy, grp_load;
  logic [3:0]           grp_ok;

  // Class code 3 indexes the constant-zero top bit, so it is never eligible.
  assign grp_ok = {1'b0, ~grp_busy & ~grp_hold};

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
    assign cls_arr[w] = warp_cls[2*w +: 2];
    assign elig[w]    = warp_valid[w] & ~stall_q[w] & grp_ok[cls_arr[w]];
  end

  // Slot 0: even warps
  logic [PER_SLOT-1:0] req0, req1;
  logic [PW-1:0]       ptr0, ptr1, idx0, idx1;
  logic                found0, found1;
  logic [WID-1:0]      wid0, wid1;
  logic [1:0]          grp0, grp1;

  for (genvar i = 0; i < PER_SLOT; i++) begin : g_slot_req
    assign req0[i] = elig[2*i];
    assign req1[i] = elig[2*i+1] & ~(found0 & (cls_arr[2*i+1] == grp0));
  end

  wis_rr_pick #(.N(PER_SLOT), .W(PW)) u_pick0 (
    .req(req0), .start(ptr0), .found(found0), .idx(idx0)
  );
  assign wid0 = {idx0, 1'b0};
  assign grp0 = cls_arr[wid0];

  // Slot 1: odd warps, after removing the group slot 0 took
  wis_rr_pick #(.N(PER_SLOT), .W(PW)) u_pick1 (
    .req(req1), .start(ptr1), .found(found1), .idx(idx1)
  );
  assign wid1 = {idx1, 1'b1};
  assign grp1 = cls_arr[wid1];

  assign iss0_valid = found0 & ~rst;
  assign iss0_warp  = wid0;
  assign iss0_grp   = grp0;
  assign iss1_valid = found1 & ~rst;
  assign iss1_warp  = wid1;
  assign iss1_grp   = grp1;

  // Round-robin pointers: next search starts after the last issued warp
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr0 <= '0;
      ptr1 <= '0;
    end else begin
      if (iss0_valid) ptr0 <= (int'(idx0) == PER_SLOT - 1) ? '0 : idx0 + 1'b1;
      if (iss1_valid) ptr1 <= (int'(idx1) == PER_SLOT - 1) ? '0 : idx1 + 1'b1;
    end
  end

  // Per-warp load stall flags
  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_stall
    logic set_w, clr_w;
    assign set_w = (iss0_valid && wid0 == WID'(w) && grp0 == GRP_LSU) ||
                   (iss1_valid && wid1 == WID'(w) && grp1 == GRP_LSU);
    assign clr_w = done_valid && (done_warp == WID'(w));
    always_ff @(posedge clk) begin
      if (rst)        stall_q[w] <= 1'b0;
      else if (set_w) stall_q[w] <= 1'b1;
      else if (clr_w) stall_q[w] <= 1'b0;
    end
  end

  // Group occupancy timers, one per group, width-dependent hold
  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    localparam int HC = (g == 0) ? ALU_HOLD : (g == 1) ? LSU_HOLD : SFU_HOLD;
    assign grp_load[g] = (iss0_valid && grp0 == 2'(g)) || (iss1_valid && grp1 == 2'(g));
    wis_grp_timer #(.HOLD(HC)) u_timer (
      .clk(clk), .rst(rst), .load(grp_load[g]), .busy(grp_busy[g])
    );
  end
endmodule

// File: rtl/wis_sched_chk.sv
module wis_sched_chk #(
  parameter int NUM_WARPS = 16,
  parameter int WARP_SIZE = 32,
  parameter int ALU_LANES = 16,
  parameter int LSU_LANES = 16,
  parameter int SFU_LANES = 4
) (
  input logic                         clk,
  input logic                         rst,
  input logic [NUM_WARPS-1:0]         warp_valid,
  input logic [2*NUM_WARPS-1:0]       warp_cls,
  input logic [2:0]                   grp_hold,
  input logic                         iss0_valid,
  input logic [$clog2(NUM_WARPS)-1:0] iss0_warp,
  input logic [1:0]                   iss0_grp,
  input logic                         iss1_valid,
  input logic [$clog2(NUM_WARPS)-1:0] iss1_warp,
  input logic [1:0]                   iss1_grp
);
  AST_RESET_QUIET: assert property (@(posedge clk) rst |-> (!iss0_valid && !iss1_valid)); // R1

  AST_SLOT0_EVEN: assert property (@(posedge clk) disable iff (rst)
    iss0_valid |-> (iss0_warp[0] == 1'b0)); // R2
  AST_SLOT1_ODD: assert property (@(posedge clk) disable iff (rst)
    iss1_valid |-> (iss1_warp[0] == 1'b1)); // R2

  AST_ISSUE_VALID: assert property (@(posedge clk) disable iff (rst)
    (iss0_valid |-> warp_valid[iss0_warp]) and (iss1_valid |-> warp_valid[iss1_warp])); // R3

  AST_GRP_DISTINCT: assert property (@(posedge clk) disable iff (rst)
    (iss0_valid && iss1_valid) |-> (iss0_grp != iss1_grp)); // R5

  AST_HOLD_RESPECT: assert property (@(posedge clk) disable iff (rst)
    (iss0_valid |-> !grp_hold[iss0_grp]) and (iss1_valid |-> !grp_hold[iss1_grp])); // R8

  AST_CLASS_MATCH: assert property (@(posedge clk) disable iff (rst)
    (iss0_valid |-> (iss0_grp == warp_cls[iss0_warp*2 +: 2])) and
    (iss1_valid |-> (iss1_grp == warp_cls[iss1_warp*2 +: 2]))); // R10

  AST_NO_CLASS3: assert property (@(posedge clk) disable iff (rst)
    (iss0_valid |-> iss0_grp != 2'd3) and (iss1_valid |-> iss1_grp != 2'd3)); // R9

  for (genvar g = 0; g < 3; g++) begin : g_gap
    localparam int HC = (g == 0) ? WARP_SIZE / ALU_LANES :
                        (g == 1) ? WARP_SIZE / LSU_LANES : WARP_SIZE / SFU_LANES;
    logic hit;
    int   since;
    assign hit = (iss0_valid && iss0_grp == 2'(g)) || (iss1_valid && iss1_grp == 2'(g));
    always_ff @(posedge clk) begin
      if (rst)            since <= HC;
      else if (hit)       since <= 1;
      else if (since < HC) since <= since + 1;
    end
    AST_GRP_GAP: assert property (@(posedge clk) disable iff (rst) hit |-> (since >= HC)); // R6
  end
endmodule

bind warp_issue_sched wis_sched_chk #(
  .NUM_WARPS(NUM_WARPS), .WARP_SIZE(WARP_SIZE),
  .ALU_LANES(ALU_LANES), .LSU_LANES(LSU_LANES), .SFU_LANES(SFU_LANES)
) u_chk (
  .clk(clk), .rst(rst), .warp_valid(warp_valid), .warp_cls(warp_cls),
  .grp_hold(grp_hold), .iss0_valid(iss0_valid), .iss0_warp(iss0_warp),
  .iss0_grp(iss0_grp), .iss1_valid(iss1_valid), .iss1_warp(iss1_warp),
  .iss1_grp(iss1_grp)
);

// File: tb/warp_issue_sched_tb.sv
module warp_issue_sched_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NW-1:0] warp_valid = '0;
  logic [2*NW-1:0] warp_cls = '0;
  logic [2:0]    grp_hold = '0;
  logic          done_valid = 1'b0;
  logic [3:0]    done_warp = '0;
  logic          iss0_valid, iss1_valid;
  logic [3:0]    iss0_warp, iss1_warp;
  logic [1:0]    iss0_grp, iss1_grp;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  warp_issue_sched u_dut (
    .clk(clk), .rst(rst), .warp_valid(warp_valid), .warp_cls(warp_cls),
    .grp_hold(grp_hold), .done_valid(done_valid), .done_warp(done_warp),
    .iss0_valid(iss0_valid), .iss0_warp(iss0_warp), .iss0_grp(iss0_grp),
    .iss1_valid(iss1_valid), .iss1_warp(iss1_warp), .iss1_grp(iss1_grp)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic set_w(int id, logic v, logic [1:0] cls);
    warp_valid[id]        = v;
    warp_cls[2*id +: 2]   = cls;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic do_reset();
    warp_valid = '0; warp_cls = '0; grp_hold = '0;
    done_valid = 1'b0; done_warp = '0;
    rst = 1'b1;
    step();
    rst = 1'b0;
  endtask

  task automatic test_reset();
    for (int w = 0; w < NW; w++) set_w(w, 1'b1, 2'd0);
    rst = 1'b1;
    step(); settle();
    chk("R1", "slot0 idle in reset", iss0_valid, 0);
    chk("R1", "slot1 idle in reset", iss1_valid, 0);
    rst = 1'b0; settle();
    chk("R1", "slot0 issues after reset", iss0_valid, 1);
    chk("R1", "slot0 lowest warp", iss0_warp, 0);
    chk("R5", "slot1 idle on arith clash", iss1_valid, 0);
  endtask

  task automatic test_round_robin();
    do_reset();
    set_w(0, 1'b1, 2'd0); set_w(2, 1'b1, 2'd0); set_w(4, 1'b1, 2'd0);
    settle();
    chk("R4", "first pick warp", iss0_warp, 0);
    chk("R2", "odd slot idle", iss1_valid, 0);
    step(); settle();
    chk("R6", "arith busy 2nd cycle", iss0_valid, 0);
    step(); settle();
    chk("R4", "second pick", iss0_warp, 2);
    step(); step(); settle();
    chk("R4", "third pick", iss0_warp, 4);
    chk("R4", "third pick valid", iss0_valid, 1);
    step(); step(); settle();
    chk("R4", "wrap pick", iss0_warp, 0);
  endtask

  task automatic test_sfu();
    do_reset();
    set_w(1, 1'b1, 2'd2);
    settle();
    chk("R2", "slot1 issues odd", iss1_warp, 1);
    chk("R2", "slot0 idle", iss0_valid, 0);
    chk("R10", "special group", iss1_grp, 2);
    for (int c = 1; c < 8; c++) begin
      step(); settle();
      chk("R6", $sformatf("special busy cycle %0d", c), iss1_valid, 0);
    end
    step(); settle();
    chk("R6", "special free at cycle 8", iss1_valid, 1);
  endtask

  task automatic test_dual();
    do_reset();
    set_w(0, 1'b1, 2'd0); set_w(1, 1'b1, 2'd1);
    settle();
    chk("R5", "dual slot0", iss0_valid, 1);
    chk("R5", "dual slot1", iss1_valid, 1);
    chk("R10", "slot0 group", iss0_grp, 0);
    chk("R10", "slot1 group", iss1_grp, 1);
    do_reset();
    set_w(0, 1'b1, 2'd0); set_w(1, 1'b1, 2'd0); set_w(3, 1'b1, 2'd2);
    settle();
    chk("R5", "slot1 skips clash warp", iss1_warp, 3);
    chk("R5", "slot1 other group", iss1_grp, 2);
  endtask

  task automatic test_stall();
    do_reset();
    set_w(2, 1'b1, 2'd1); set_w(4, 1'b1, 2'd0);
    settle();
    chk("R7", "load issues", iss0_warp, 2);
    chk("R7", "load group", iss0_grp, 1);
    step(); settle();
    chk("R7", "other warp hides stall", iss0_warp, 4);
    step(); settle();
    chk("R3", "stalled and busy idle", iss0_valid, 0);
    step(); settle();
    chk("R3", "stalled warp skipped", iss0_warp, 4);
    done_valid = 1'b1; done_warp = 4'd2; settle();
    chk("R7", "no bypass on completion", iss0_warp, 4);
    step(); done_valid = 1'b0; settle();
    chk("R7", "warp free after completion", iss0_warp, 2);
    chk("R7", "free warp valid", iss0_valid, 1);
  endtask

  task automatic test_hold();
    do_reset();
    set_w(0, 1'b1, 2'd0); set_w(1, 1'b1, 2'd1);
    grp_hold = 3'b001; settle();
    chk("R8", "held arith no issue", iss0_valid, 0);
    chk("R8", "load group unaffected", iss1_valid, 1);
    step(); settle();
    chk("R8", "still held", iss0_valid, 0);
    grp_hold = 3'b000; settle();
    chk("R8", "release issues", iss0_valid, 1);
  endtask

  task automatic test_class3();
    do_reset();
    set_w(0, 1'b1, 2'd3); set_w(2, 1'b0, 2'd0);
    settle();
    chk("R9", "class 3 never issues", iss0_valid, 0);
    step(); settle();
    chk("R3", "invalid warp ignored", iss0_valid, 0);
    set_w(0, 1'b1, 2'd0); settle();
    chk("R10", "arith class issues", iss0_valid, 1);
  endtask

  initial begin
    test_reset();
    test_round_robin();
    test_sfu();
    test_dual();
    test_stall();
    test_hold();
    test_class3();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule